// File: doc/BRIEF.md
# I2C Bus Line Monitor

This block watches the clock and data lines of an I2C bus and reports what is happening on them. It passes both raw lines through its own synchronizer flops. From the synchronized samples it finds start, repeated start and stop conditions. It keeps a bus-occupied flag and the role flags of the local interface: whether it acts as master, and whether it is sending data. It also flags a misplaced start or stop that lands inside a byte transfer.

The protocol engine supplies several inputs:
- whether the transfer is currently mid-byte;
- a strobe at the end of the address phase, together with the direction bit;
- a strobe when it has generated a start as master;
- a strobe when it loses arbitration.

Software supplies the peripheral enable and a strobe that clears the bus-error flag. The line tracking and the bus-occupied flag keep running while the peripheral is disabled. All other flags are held cleared while it is disabled.

Top module: `i2c_line_monitor`

## Requirements
- R1: After reset, `busy`, `master`, `transmitting` and `bus_err` are 0, and no condition pulse is asserted while the lines are idle high.
- R2: A start is SDA going 1→0 while SCL is 1 in two consecutive synchronized samples. Suppose the raw SDA change is captured at clock edge n. With `busy` at 0, `start_pulse` is then high for exactly one cycle, after edge n+1.
- R3: A start detected while `busy` is already 1 is reported on `rstart_pulse` instead of `start_pulse`, with the same timing as R2.
- R4: A stop is SDA going 0→1 while SCL is 1. It gives a one-cycle `stop_pulse` with the timing of R2, and `busy` reads 0 after edge n+2.
- R5: `busy` becomes 1 one edge after either synchronized line is seen low, and it stays 1 until a stop. This holds whatever the value of `enable`.
- R6: With `enable` at 1, `bus_err` becomes 1 after edge n+2 when a start or stop is detected while `mid_byte` is 1. A start or stop detected with `mid_byte` at 0 leaves it unchanged.
- R7: A one-cycle `berr_clr` clears `bus_err` on the next edge. If a new misplaced condition is detected in the same cycle as `berr_clr`, the flag stays at 1. `enable` at 0 clears it.
- R8: `start_gen` with `enable` at 1 sets `master` on the next edge. A detected stop, `arb_lost`, or `enable` at 0 clears `master`. If a clear and `start_gen` arrive in the same cycle, the clear wins.
- R9: `addr_done` loads `rw_bit` into `transmitting` on the next edge, where 1 means data is sent. A detected stop, a repeated start, `arb_lost`, or `enable` at 0 clears `transmitting`. If a clear and `addr_done` arrive in the same cycle, the clear wins.
- R10: `start_gen` while `enable` is 0 leaves `master` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| enable | input | 1 | Peripheral enable |
| mid_byte | input | 1 | High while a byte transfer is in progress |
| addr_done | input | 1 | Strobe at the end of the address phase |
| rw_bit | input | 1 | Direction for `addr_done`: 1 = transmit |
| start_gen | input | 1 | Strobe: local master generated a start |
| arb_lost | input | 1 | Strobe: arbitration lost |
| berr_clr | input | 1 | Strobe: software clears the bus-error flag |
| busy | output | 1 | Bus occupied |
| master | output | 1 | Local interface is master |
| transmitting | output | 1 | Local interface sends data bytes |
| bus_err | output | 1 | Misplaced start or stop seen |
| start_pulse | output | 1 | Start on an idle bus, one cycle |
| rstart_pulse | output | 1 | Repeated start, one cycle |
| stop_pulse | output | 1 | Stop, one cycle |

## Verification
Two pairs of functions can coincide in one cycle.

The first pair is the load of the direction bit and the repeated-start clear of `transmitting`. The bench raises `addr_done` in the very cycle in which `rstart_pulse` is visible. It judges that `transmitting` reads 0 afterwards.

The second pair is a new misplaced condition and the software clear of `bus_err`. The bench drives `berr_clr` in the cycle in which a start with `mid_byte` high is being detected. It expects the flag to remain set.

// File: rtl/i2c_line_monitor.sv
module i2c_line_monitor #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic enable,
  input  logic mid_byte,
  input  logic addr_done,
  input  logic rw_bit,
  input  logic start_gen,
  input  logic arb_lost,
  input  logic berr_clr,
  output logic busy,
  output logic master,
  output logic transmitting,
  output logic bus_err,
  output logic start_pulse,
  output logic rstart_pulse,
  output logic stop_pulse
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_sync, sda_sync;
  logic         scl_prev, sda_prev;
  logic         scl_q, sda_q;
  logic         start_det, stop_det;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[TOP-1:0], scl_in};
      sda_sync <= {sda_sync[TOP-1:0], sda_in};
      scl_prev <= scl_sync[TOP];
      sda_prev <= sda_sync[TOP];
    end
  end

  assign scl_q     = scl_sync[TOP];
  assign sda_q     = sda_sync[TOP];
  assign start_det = scl_q & scl_prev & sda_prev & ~sda_q;
  assign stop_det  = scl_q & scl_prev & ~sda_prev & sda_q;

  assign start_pulse  = start_det & ~busy;
  assign rstart_pulse = start_det & busy;
  assign stop_pulse   = stop_det;

  always_ff @(posedge clk) begin
    if (!rst_n)                busy <= 1'b0;
    else if (stop_det)         busy <= 1'b0;
    else if (!scl_q || !sda_q) busy <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                  bus_err <= 1'b0;
    else if (!enable)                            bus_err <= 1'b0;
    else if ((start_det || stop_det) && mid_byte) bus_err <= 1'b1;
    else if (berr_clr)                           bus_err <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                               master <= 1'b0;
    else if (!enable || stop_det || arb_lost) master <= 1'b0;
    else if (start_gen)                       master <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                               transmitting <= 1'b0;
    else if (!enable || stop_det || rstart_pulse || arb_lost) transmitting <= 1'b0;
    else if (addr_done)                                       transmitting <= rw_bit;
  end

endmodule

// File: rtl/i2c_line_monitor_sva.sv
module i2c_line_monitor_sva (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic mid_byte,
  input logic start_gen,
  input logic arb_lost,
  input logic busy,
  input logic master,
  input logic transmitting,
  input logic bus_err,
  input logic start_pulse,
  input logic rstart_pulse,
  input logic stop_pulse
);

  p_start_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  p_start_marks_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> busy);

  p_rstart_needs_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rstart_pulse |-> busy);

  p_stop_frees_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> !busy);

  p_berr_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_err) |-> $past(enable && mid_byte && (start_pulse || rstart_pulse || stop_pulse)));

  p_berr_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !bus_err);

  p_master_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost || stop_pulse || !enable) |=> !master);

  p_tx_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_pulse || rstart_pulse || arb_lost || !enable) |=> !transmitting);

  p_master_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(master) |-> $past(start_gen && enable));

endmodule

bind i2c_line_monitor i2c_line_monitor_sva u_sva (
  .clk(clk), .rst_n(rst_n), .enable(enable), .mid_byte(mid_byte),
  .start_gen(start_gen), .arb_lost(arb_lost), .busy(busy), .master(master),
  .transmitting(transmitting), .bus_err(bus_err), .start_pulse(start_pulse),
  .rstart_pulse(rstart_pulse), .stop_pulse(stop_pulse)
);

// File: tb/i2c_line_monitor_tb.sv
module i2c_line_monitor_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1, enable = 1'b1, mid_byte = 1'b0;
  logic addr_done = 1'b0, rw_bit = 1'b0, start_gen = 1'b0, arb_lost = 1'b0, berr_clr = 1'b0;
  logic busy, master, transmitting, bus_err, start_pulse, rstart_pulse, stop_pulse;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  i2c_line_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .enable(enable),
    .mid_byte(mid_byte), .addr_done(addr_done), .rw_bit(rw_bit), .start_gen(start_gen),
    .arb_lost(arb_lost), .berr_clr(berr_clr), .busy(busy), .master(master),
    .transmitting(transmitting), .bus_err(bus_err), .start_pulse(start_pulse),
    .rstart_pulse(rstart_pulse), .stop_pulse(stop_pulse)
  );

  // {scl, sda, mid_byte, exp_start, exp_rstart, exp_stop, exp_busy, exp_berr}
  localparam logic [7:0] VEC [12] = '{
    8'b1_0_0_1_0_0_1_0,
    8'b0_0_0_0_0_0_1_0,
    8'b0_1_0_0_0_0_1_0,
    8'b1_1_0_0_0_0_1_0,
    8'b1_0_0_0_1_0_1_0,
    8'b0_0_0_0_0_0_1_0,
    8'b1_0_0_0_0_0_1_0,
    8'b1_1_0_0_0_1_0_0,
    8'b0_1_0_0_0_0_1_0,
    8'b1_1_0_0_0_0_1_0,
    8'b1_0_1_0_1_0_1_1,
    8'b1_1_1_0_0_1_0_1
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic bus(input logic c, input logic d);
    scl_in = c;
    sda_in = d;
    tick(3);
  endtask

  task automatic strobe_start_gen();
    start_gen = 1'b1; tick(1); start_gen = 1'b0;
  endtask

  task automatic load_dir(input logic d);
    addr_done = 1'b1; rw_bit = d; tick(1); addr_done = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R1 busy after reset", busy, 1'b0);
    chk("R1 master after reset", master, 1'b0);
    chk("R1 transmitting after reset", transmitting, 1'b0);
    chk("R1 bus_err after reset", bus_err, 1'b0);
    chk("R1 no start pulse idle", start_pulse, 1'b0);
    chk("R1 no stop pulse idle", stop_pulse, 1'b0);

    for (int i = 0; i < 12; i++) begin
      scl_in = VEC[i][7]; sda_in = VEC[i][6]; mid_byte = VEC[i][5];
      tick(2);
      chk($sformatf("R2 row %0d start_pulse", i), start_pulse, VEC[i][4]);
      chk($sformatf("R3 row %0d rstart_pulse", i), rstart_pulse, VEC[i][3]);
      chk($sformatf("R4 row %0d stop_pulse", i), stop_pulse, VEC[i][2]);
      tick(1);
      chk($sformatf("R2 row %0d pulse gone", i), start_pulse | rstart_pulse | stop_pulse, 1'b0);
      chk($sformatf("R5 row %0d busy", i), busy, VEC[i][1]);
      chk($sformatf("R6 row %0d bus_err", i), bus_err, VEC[i][0]);
    end

    // R7: clear, set-wins, disable clear
    berr_clr = 1'b1; tick(1); berr_clr = 1'b0;
    chk("R7 berr_clr clears", bus_err, 1'b0);
    mid_byte = 1'b1; sda_in = 1'b0;
    tick(2);
    chk("R2 start during clear cycle", start_pulse, 1'b1);
    berr_clr = 1'b1; tick(1); berr_clr = 1'b0;
    chk("R7 new error beats clear", bus_err, 1'b1);
    berr_clr = 1'b1; tick(1); berr_clr = 1'b0;
    chk("R7 clear after coincidence", bus_err, 1'b0);
    sda_in = 1'b1; tick(3);
    chk("R6 stop mid-byte sets bus_err", bus_err, 1'b1);
    enable = 1'b0; tick(1);
    chk("R7 disable clears bus_err", bus_err, 1'b0);
    mid_byte = 1'b0;

    // R5 / R10 while disabled
    bus(1'b0, 1'b1);
    chk("R5 busy tracks while disabled", busy, 1'b1);
    strobe_start_gen();
    chk("R10 start_gen ignored when disabled", master, 1'b0);
    bus(1'b0, 1'b0);
    bus(1'b1, 1'b0);
    bus(1'b1, 1'b1);
    chk("R5 stop clears busy while disabled", busy, 1'b0);
    enable = 1'b1; tick(1);

    // R8
    strobe_start_gen();
    chk("R8 start_gen sets master", master, 1'b1);
    arb_lost = 1'b1; tick(1); arb_lost = 1'b0;
    chk("R8 arb_lost clears master", master, 1'b0);
    strobe_start_gen();
    enable = 1'b0; tick(1); enable = 1'b1;
    chk("R8 disable clears master", master, 1'b0);
    start_gen = 1'b1; arb_lost = 1'b1; tick(1); start_gen = 1'b0; arb_lost = 1'b0;
    chk("R8 arb_lost wins over start_gen", master, 1'b0);
    strobe_start_gen();
    bus(1'b1, 1'b0);
    chk("R8 master holds through start", master, 1'b1);
    bus(1'b1, 1'b1);
    chk("R8 stop clears master", master, 1'b0);

    // R9
    load_dir(1'b1);
    chk("R9 rw_bit 1 loads transmit", transmitting, 1'b1);
    load_dir(1'b0);
    chk("R9 rw_bit 0 loads receive", transmitting, 1'b0);
    load_dir(1'b1);
    arb_lost = 1'b1; tick(1); arb_lost = 1'b0;
    chk("R9 arb_lost clears transmitting", transmitting, 1'b0);
    load_dir(1'b1);
    enable = 1'b0; tick(1); enable = 1'b1;
    chk("R9 disable clears transmitting", transmitting, 1'b0);
    bus(1'b1, 1'b0);
    load_dir(1'b1);
    bus(1'b0, 1'b0);
    chk("R9 transmitting holds on clock low", transmitting, 1'b1);
    bus(1'b0, 1'b1);
    bus(1'b1, 1'b1);
    sda_in = 1'b0;
    tick(2);
    chk("R3 repeated start seen", rstart_pulse, 1'b1);
    addr_done = 1'b1; rw_bit = 1'b1; tick(1); addr_done = 1'b0;
    chk("R9 repeated start wins over load", transmitting, 1'b0);
    tick(1);
    load_dir(1'b1);
    chk("R9 reload after repeated start", transmitting, 1'b1);
    bus(1'b1, 1'b1);
    chk("R9 stop clears transmitting", transmitting, 1'b0);
    chk("R4 bus idle after final stop", busy, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule